// File: doc/BRIEF.md
# Timed-Access Write Protection Gate

This block keeps a small set of critical control bits from being changed by stray or runaway software. It watches the register write bus and a one-clock machine-cycle tick. It raises a one-cycle qualifier, `prot_wr_ok`, only when a write to a protected address arrives inside a short unlock window. Opening that window takes two key writes to one dedicated key address: first AAh, then 55h. The second must arrive within a bounded number of machine-cycle ticks after the first. The window then stays open for the same number of ticks.

Unlocking depends on the address written, the value written and the timing, all together. Extra time between steps cancels the attempt, for example an interrupt service routine that runs in between. One protected write uses up the unlock. The protected registers themselves sit outside this block. They AND their own write strobe with `prot_wr_ok`. A write that does not get the qualifier leaves them unchanged.

Top module: `timed_access_gate`

## Requirements
- R1: After reset the gate is idle and locked: `unlocked` is 0 and a write to a protected address gives `prot_wr_ok` = 0.
- R2: A write of AAh to the key address, then a write of 55h to the key address with at most two `mc_tick` pulses between them, opens the window: `unlocked` reads 1 from the clock edge that takes the 55h write.
- R3: If the third `mc_tick` after the AAh write comes before the 55h write, the first step is discarded and the later 55h write does not open the window.
- R4: While waiting for 55h, a key write of any other value (AAh included) aborts the sequence and returns the gate to idle, so a following 55h does not unlock.
- R5: `prot_wr_ok` is high in the same cycle as a write to a protected address only while the window is open, and it stays low for every write to any other address.
- R6: The window closes on the third `mc_tick` after the 55h write. A protected write after that gets no qualifier.
- R7: After one protected write has been granted, the gate is locked again (`unlocked` = 0). A second protected write is refused until a new full key sequence is written.
- R8: Writes to addresses that are neither the key address nor protected, and protected writes refused while waiting for 55h, do not disturb a sequence in progress.
- R9: A 55h key write that is not preceded by an accepted AAh step does not unlock.
- R10: A protected write in the same clock as the third window tick is still granted. A tick in the same clock as a key write is not counted against the new step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Register write strobe, one clock per write |
| bus_addr | input | AW (8) | Write address |
| bus_wdata | input | DW (8) | Write data |
| mc_tick | input | 1 | One-clock pulse per machine cycle |
| prot_wr_ok | output | 1 | Write qualifier for the protected registers |
| unlocked | output | 1 | Status: protected-write window currently open |

## Verification
The hardest case to reach is the exact tick boundary where the key step or protected write is just still in time versus just too late. Its position depends on how many machine-cycle ticks fall between two bus writes. The bench covers it by sweeping both gaps, from the AAh step to the 55h step and from the 55h step to the protected write, over zero to four ticks. It also places a tick in the same clock as the protected write. A separate sweep writes every possible byte as the second key step to prove that only 55h unlocks.

// File: rtl/ta_pkg.sv
package ta_pkg;
  typedef enum logic [1:0] {
    TA_IDLE  = 2'd0,
    TA_ARMED = 2'd1,
    TA_OPEN  = 2'd2
  } ta_state_e;
endpackage

// File: rtl/ta_reset_sync.sv
module ta_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ta_addr_match.sv
module ta_addr_match #(
  parameter int AW = 8,
  parameter int NPROT = 2,
  parameter logic [NPROT*AW-1:0] PROT_LIST = {8'hD8, 8'h87},
  parameter logic [AW-1:0] KEY_ADDR = 8'hC7
) (
  input  logic          wr,
  input  logic [AW-1:0] addr,
  output logic          key_wr,
  output logic          prot_wr
);
  logic [NPROT-1:0] hit;

  for (genvar i = 0; i < NPROT; i++) begin : g_cmp
    assign hit[i] = (addr == PROT_LIST[i*AW +: AW]);
  end

  assign key_wr  = wr && (addr == KEY_ADDR);
  assign prot_wr = wr && (|hit);
endmodule

// File: rtl/ta_window_timer.sv
module ta_window_timer #(
  parameter int WIN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LAST = CW'(WIN - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign expire = run && tick && !restart && (cnt_q == LAST);
  assign cnt_en = restart || (run && tick);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)     cnt_d = '0;
    else if (expire) cnt_d = '0;
    else if (run && tick) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/ta_key_seq.sv
module ta_key_seq
  import ta_pkg::*;
#(
  parameter int DW = 8,
  parameter logic [DW-1:0] KEY1 = 8'hAA,
  parameter logic [DW-1:0] KEY2 = 8'h55
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_wr,
  input  logic          prot_wr,
  input  logic [DW-1:0] wdata,
  input  logic          expire,
  output logic          restart,
  output logic          run,
  output logic          grant,
  output logic          is_open
);
  ta_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    restart = 1'b0;
    unique case (state_q)
      TA_IDLE: begin
        if (key_wr && wdata == KEY1) begin
          state_d = TA_ARMED;
          restart = 1'b1;
        end
      end
      TA_ARMED: begin
        if (key_wr) begin
          if (wdata == KEY2) begin
            state_d = TA_OPEN;
            restart = 1'b1;
          end else begin
            state_d = TA_IDLE;
          end
        end else if (expire) begin
          state_d = TA_IDLE;
        end
      end
      TA_OPEN: begin
        if (key_wr) begin
          if (wdata == KEY1) begin
            state_d = TA_ARMED;
            restart = 1'b1;
          end else begin
            state_d = TA_IDLE;
          end
        end else if (prot_wr || expire) begin
          state_d = TA_IDLE;
        end
      end
      default: state_d = TA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= TA_IDLE;
    else        state_q <= state_d;
  end

  assign run     = (state_q != TA_IDLE);
  assign is_open = (state_q == TA_OPEN);
  assign grant   = is_open && prot_wr;

  assert_one_shot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (state_q == TA_IDLE));
  assert_open_needs_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TA_OPEN && $past(state_q) != TA_OPEN) |->
      $past(key_wr && wdata == KEY2 && state_q == TA_ARMED));
  assert_abort_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == TA_ARMED && key_wr && wdata != KEY2) |=> (state_q == TA_IDLE));
  assert_expire_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !key_wr) |=> (state_q == TA_IDLE));
endmodule

// File: rtl/timed_access_gate.sv
module timed_access_gate #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int NPROT = 2,
  parameter logic [NPROT*AW-1:0] PROT_LIST = {8'hD8, 8'h87},
  parameter logic [AW-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DW-1:0] KEY1 = 8'hAA,
  parameter logic [DW-1:0] KEY2 = 8'h55,
  parameter int WIN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          mc_tick,
  output logic          prot_wr_ok,
  output logic          unlocked
);
  logic rst_s;
  logic key_wr, prot_wr;
  logic restart, run, expire;

  ta_reset_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_s)
  );

  ta_addr_match #(
    .AW(AW), .NPROT(NPROT), .PROT_LIST(PROT_LIST), .KEY_ADDR(KEY_ADDR)
  ) u_match (
    .wr(bus_wr), .addr(bus_addr), .key_wr(key_wr), .prot_wr(prot_wr)
  );

  ta_window_timer #(.WIN(WIN)) u_timer (
    .clk(clk), .rst_n(rst_s), .restart(restart), .run(run),
    .tick(mc_tick), .expire(expire)
  );

  ta_key_seq #(.DW(DW), .KEY1(KEY1), .KEY2(KEY2)) u_seq (
    .clk(clk), .rst_n(rst_s), .key_wr(key_wr), .prot_wr(prot_wr),
    .wdata(bus_wdata), .expire(expire), .restart(restart), .run(run),
    .grant(prot_wr_ok), .is_open(unlocked)
  );

  assert_grant_bus_R5: assert property (@(posedge clk) disable iff (!rst_s)
    prot_wr_ok |-> (bus_wr && bus_addr != KEY_ADDR));
  assert_reset_locked_R1: assert property (@(posedge clk)
    $rose(rst_s) |-> !unlocked);
endmodule

// File: tb/timed_access_gate_test.sv
`timescale 1ns/1ps
module timed_access_gate_test;
  localparam logic [7:0] KA = 8'hC7;
  localparam logic [7:0] PA0 = 8'h87;
  localparam logic [7:0] PA1 = 8'hD8;
  localparam logic [7:0] UA = 8'h10;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_wr;
  logic [7:0] bus_addr, bus_wdata;
  logic mc_tick;
  logic prot_wr_ok, unlocked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic s_ok, s_unl;

  always #4 clk = ~clk;

  timed_access_gate uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .mc_tick(mc_tick),
    .prot_wr_ok(prot_wr_ok), .unlocked(unlocked)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  // one clock: s_ok = qualifier during the cycle, s_unl = status after the edge
  task automatic cyc(input logic we, input logic [7:0] a, input logic [7:0] d,
                     input logic tk);
    @(negedge clk);
    bus_wr = we; bus_addr = a; bus_wdata = d; mc_tick = tk;
    #1 s_ok = prot_wr_ok;
    @(posedge clk);
    #1;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; mc_tick = 1'b0;
    s_unl = unlocked;
  endtask

  task automatic close_gate();
    cyc(1'b1, KA, 8'h00, 1'b0);
    cyc(1'b1, KA, 8'h00, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; mc_tick = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    check("R1 unlocked after reset", unlocked, 1'b0);
    cyc(1'b1, PA0, 8'hFF, 1'b0);
    check("R1 protected write after reset", s_ok, 1'b0);

    // R9 lone 55h
    cyc(1'b1, KA, 8'h55, 1'b0);
    check("R9 55h without AAh", s_unl, 1'b0);

    // R2 R3 R5 R6 R7 sweep over both tick gaps
    for (int g1 = 0; g1 < 5; g1++) begin
      for (int g2 = 0; g2 < 5; g2++) begin
        close_gate();
        cyc(1'b1, KA, 8'hAA, 1'b0);
        for (int k = 0; k < g1; k++) cyc(1'b0, 8'h00, 8'h00, 1'b1);
        cyc(1'b1, KA, 8'h55, 1'b0);
        check(g1 < 3 ? "R2 window opens" : "R3 late second key", s_unl, g1 < 3);
        for (int k = 0; k < g2; k++) cyc(1'b0, 8'h00, 8'h00, 1'b1);
        cyc(1'b1, (g2 % 2) ? PA1 : PA0, 8'h5A, 1'b0);
        check((g1 < 3 && g2 >= 3) ? "R6 window expired" : "R5 grant in window",
              s_ok, (g1 < 3) && (g2 < 3));
        check("R7 relocked", s_unl, 1'b0);
        cyc(1'b1, PA0, 8'h01, 1'b0);
        check("R7 second write refused", s_ok, 1'b0);
      end
    end

    // R4 every value as second step
    for (int v = 0; v < 256; v++) begin
      close_gate();
      cyc(1'b1, KA, 8'hAA, 1'b0);
      cyc(1'b1, KA, 8'(v), 1'b0);
      check("R4 only 55h unlocks", s_unl, v == 8'h55);
      if (v != 8'h55) begin
        cyc(1'b1, KA, 8'h55, 1'b0);
        check("R4 aborted sequence stays locked", s_unl, 1'b0);
      end
    end

    // R8 unrelated and refused writes do not disturb the sequence
    close_gate();
    cyc(1'b1, KA, 8'hAA, 1'b0);
    cyc(1'b1, UA, 8'h55, 1'b0);
    check("R5 unprotected write no grant", s_ok, 1'b0);
    cyc(1'b1, PA1, 8'h33, 1'b1);
    check("R8 protected write refused while armed", s_ok, 1'b0);
    cyc(1'b1, KA, 8'h55, 1'b0);
    check("R8 sequence survives other writes", s_unl, 1'b1);
    cyc(1'b1, UA, 8'h00, 1'b0);
    check("R8 open survives unprotected write", s_unl, 1'b1);
    cyc(1'b1, PA1, 8'h77, 1'b0);
    check("R5 grant after other writes", s_ok, 1'b1);

    // R10 tick coinciding with protected write on the last window tick
    close_gate();
    cyc(1'b1, KA, 8'hAA, 1'b1);
    cyc(1'b0, 8'h00, 8'h00, 1'b1);
    cyc(1'b0, 8'h00, 8'h00, 1'b1);
    cyc(1'b1, KA, 8'h55, 1'b1);
    check("R10 key write on third tick counts", s_unl, 1'b1);
    cyc(1'b0, 8'h00, 8'h00, 1'b1);
    cyc(1'b0, 8'h00, 8'h00, 1'b1);
    cyc(1'b1, PA0, 8'h11, 1'b1);
    check("R10 grant on closing tick", s_ok, 1'b1);
    check("R10 closed after", s_unl, 1'b0);

    // R6 status drops on third tick with no write
    close_gate();
    cyc(1'b1, KA, 8'hAA, 1'b0);
    cyc(1'b1, KA, 8'h55, 1'b0);
    cyc(1'b0, 8'h00, 8'h00, 1'b1);
    cyc(1'b0, 8'h00, 8'h00, 1'b1);
    check("R6 open before third tick", s_unl, 1'b1);
    cyc(1'b0, 8'h00, 8'h00, 1'b1);
    check("R6 closed at third tick", s_unl, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule